// File: doc/BRIEF.md
# Backup Switchover and Seal Sequencer

This block decides which source feeds the RAM supply output: the main supply or the backup battery. It takes two comparator flags, one for supply above the reset threshold and one for supply above the battery voltage. The output moves to the battery only when both flags are low. Any change between the two sources passes through one cycle with neither switch closed.

The block also drives the power-fail output. That output is forced high while the reset timeout runs. It is forced low when the supply is below the battery. Otherwise it follows the power-fail comparator.

The block holds a ship-mode seal that keeps the battery off the output until the board is first powered for real. During a reset timeout the block reads an external arming pin twice, at one half and at three quarters of the timeout. If the pin is low both times, with manual reset high, the seal is armed. An armed seal keeps the battery disconnected through the next supply loss. It clears only when the supply next rises above the threshold.

Top module: `bbs_seq`

## Requirements
- R1: While `vcc_ok_i` is high, the settled selection is the main supply: `sel_main_o`=1, `sel_bat_o`=0.
- R2: While `vcc_ok_i` is low and `vcc_gt_bat_i` is high, the settled selection is the main supply.
- R3: While both `vcc_ok_i` and `vcc_gt_bat_i` are low and the seal is not armed, the settled selection is the battery: `sel_bat_o`=1, `sel_main_o`=0.
- R4: The two selects are never high together. When the required selection changes from one source to the other, the cycle after the change shows both selects low, and the cycle after that shows the new source.
- R5: While `tmo_active_i` is high and `vcc_gt_bat_i` is high, `pfo_o` is 1 one cycle later, whatever `pf_cmp_i` is.
- R6: While `vcc_gt_bat_i` is low, `pfo_o` is 0 one cycle later, whatever the other inputs are.
- R7: With `tmo_active_i` low and `vcc_gt_bat_i` high, `pfo_o` equals `pf_cmp_i` delayed by one cycle.
- R8: If `arm_pin_i` is 0 and `mr_ni` is 1 at the half-timeout count (`tmo_cnt_i`=TMO_CYCLES/2) and again at the three-quarter count (`tmo_cnt_i`=3*TMO_CYCLES/4), both while `tmo_active_i` is high, then `seal_o` is 1 from the cycle after the three-quarter count.
- R9: If `arm_pin_i` is 1 or `mr_ni` is 0 at either sample count, the seal is not armed in that timeout.
- R10: While the seal is armed, the battery is never selected, and `mr_ni` has no effect on `seal_o`. With both supply flags low, both selects stay low.
- R11: An armed seal stays armed until `vcc_ok_i` rises. `seal_o` is 0 in the cycle after that rising edge.
- R12: During reset, `sel_main_o`, `sel_bat_o`, `seal_o` and `pfo_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vcc_ok_i | input | 1 | Supply above reset threshold |
| vcc_gt_bat_i | input | 1 | Supply above battery voltage |
| tmo_active_i | input | 1 | Reset timeout in progress |
| tmo_cnt_i | input | CNT_W | Elapsed cycles of the reset timeout |
| mr_ni | input | 1 | Manual reset level, active low |
| arm_pin_i | input | 1 | Sensed level of the arming pin |
| pf_cmp_i | input | 1 | Power-fail comparator result, 1 when the input is above its threshold |
| sel_main_o | output | 1 | Connect the output to the main supply |
| sel_bat_o | output | 1 | Connect the output to the battery |
| seal_o | output | 1 | Seal armed, battery held off |
| pfo_o | output | 1 | Power-fail output level |

## Verification
The arming logic is swept over all sixteen combinations of pin level and manual-reset level at the two sample counts. This separates a full arm from each single-sample miss and from a manual-reset block. For every combination, the bench then removes the supply with manual reset held low, which shows whether the battery connects. It also checks that the seal persists while the supply stays below threshold and clears on the next rise. The switch is tried on every ordered pair of supply-flag states, which exposes both the break cycle and the cases where no change should occur. The power-fail output is driven through all eight combinations of timeout, battery compare and comparator input, which checks the order in which its conditions take priority.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef enum logic [1:0] {
    SW_NONE = 2'b00,
    SW_MAIN = 2'b01,
    SW_BAT  = 2'b10
  } sw_sel_e;
endpackage

// File: rtl/bbs_seal_arm.sv
module bbs_seal_arm #(
  parameter int TMO_CYCLES = 4096,
  localparam int CNT_W = $clog2(TMO_CYCLES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vcc_ok_i,
  input  logic             tmo_active_i,
  input  logic [CNT_W-1:0] tmo_cnt_i,
  input  logic             mr_ni,
  input  logic             arm_pin_i,
  output logic             armed_o
);
  localparam logic [CNT_W-1:0] HALF_PT = CNT_W'(TMO_CYCLES / 2);
  localparam logic [CNT_W-1:0] Q3_PT   = CNT_W'((TMO_CYCLES * 3) / 4);

  logic half_ok_q, vcc_ok_q, armed_q;
  logic arm_lvl, vcc_rise;

  assign arm_lvl  = !arm_pin_i && mr_ni;
  assign vcc_rise = vcc_ok_i && !vcc_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_ok_q <= 1'b0;
      vcc_ok_q  <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      vcc_ok_q <= vcc_ok_i;
      if (!tmo_active_i) half_ok_q <= 1'b0;
      else if (tmo_cnt_i == HALF_PT) half_ok_q <= arm_lvl;
      // rise of supply has priority over a same-cycle arm
      if (vcc_rise) armed_q <= 1'b0;
      else if (tmo_active_i && tmo_cnt_i == Q3_PT && half_ok_q && arm_lvl)
        armed_q <= 1'b1;
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/bbs_sw_fsm.sv
module bbs_sw_fsm
  import bbs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_ok_i,
  input  logic vcc_gt_bat_i,
  input  logic armed_i,
  output logic sel_main_o,
  output logic sel_bat_o
);
  sw_sel_e state_q, target, state_d;

  always_comb begin
    if (vcc_ok_i || vcc_gt_bat_i) target = SW_MAIN;
    else if (armed_i)             target = SW_NONE;
    else                          target = SW_BAT;
  end

  // break before make: leave a closed switch through NONE
  always_comb begin
    if (state_q == target)        state_d = state_q;
    else if (state_q == SW_NONE)  state_d = target;
    else                          state_d = SW_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SW_NONE;
    else         state_q <= state_d;
  end

  assign sel_main_o = (state_q == SW_MAIN);
  assign sel_bat_o  = (state_q == SW_BAT);
endmodule

// File: rtl/bbs_pfo_ctl.sv
module bbs_pfo_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_gt_bat_i,
  input  logic tmo_active_i,
  input  logic pf_cmp_i,
  output logic pfo_o
);
  logic pfo_d, pfo_q;

  always_comb begin
    if (!vcc_gt_bat_i)     pfo_d = 1'b0;
    else if (tmo_active_i) pfo_d = 1'b1;
    else                   pfo_d = pf_cmp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pfo_q <= 1'b0;
    else         pfo_q <= pfo_d;
  end

  assign pfo_o = pfo_q;
endmodule

// File: rtl/bbs_seq.sv
module bbs_seq #(
  parameter int TMO_CYCLES = 4096,
  localparam int CNT_W = $clog2(TMO_CYCLES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vcc_ok_i,
  input  logic             vcc_gt_bat_i,
  input  logic             tmo_active_i,
  input  logic [CNT_W-1:0] tmo_cnt_i,
  input  logic             mr_ni,
  input  logic             arm_pin_i,
  input  logic             pf_cmp_i,
  output logic             sel_main_o,
  output logic             sel_bat_o,
  output logic             seal_o,
  output logic             pfo_o
);
  logic armed;

  bbs_seal_arm #(.TMO_CYCLES(TMO_CYCLES)) u_arm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vcc_ok_i     (vcc_ok_i),
    .tmo_active_i (tmo_active_i),
    .tmo_cnt_i    (tmo_cnt_i),
    .mr_ni        (mr_ni),
    .arm_pin_i    (arm_pin_i),
    .armed_o      (armed)
  );

  bbs_sw_fsm u_sw (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vcc_ok_i     (vcc_ok_i),
    .vcc_gt_bat_i (vcc_gt_bat_i),
    .armed_i      (armed),
    .sel_main_o   (sel_main_o),
    .sel_bat_o    (sel_bat_o)
  );

  bbs_pfo_ctl u_pfo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vcc_gt_bat_i (vcc_gt_bat_i),
    .tmo_active_i (tmo_active_i),
    .pf_cmp_i     (pf_cmp_i),
    .pfo_o        (pfo_o)
  );

  assign seal_o = armed;
endmodule

// File: rtl/bbs_seq_chk.sv
module bbs_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic vcc_ok_i,
  input logic vcc_gt_bat_i,
  input logic tmo_active_i,
  input logic sel_main_o,
  input logic sel_bat_o,
  input logic seal_o,
  input logic pfo_o
);
  // R4
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_main_o, sel_bat_o}));
  // R4
  main_break_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_main_o |=> !sel_bat_o);
  // R4
  bat_break_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_bat_o |=> !sel_main_o);
  // R3
  bat_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_bat_o) |-> $past(!vcc_ok_i && !vcc_gt_bat_i));
  // R10
  seal_no_bat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seal_o |-> !sel_bat_o);
  // R5
  pfo_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_active_i && vcc_gt_bat_i) |=> pfo_o);
  // R6
  pfo_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_gt_bat_i |=> !pfo_o);
  // R11
  seal_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vcc_ok_i) |=> !seal_o);
  // R11
  seal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seal_o && !$rose(vcc_ok_i)) |=> seal_o);
endmodule

bind bbs_seq bbs_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .vcc_ok_i     (vcc_ok_i),
  .vcc_gt_bat_i (vcc_gt_bat_i),
  .tmo_active_i (tmo_active_i),
  .sel_main_o   (sel_main_o),
  .sel_bat_o    (sel_bat_o),
  .seal_o       (seal_o),
  .pfo_o        (pfo_o)
);

// File: tb/bbs_seq_bench.sv
module bbs_seq_bench;
  localparam int TMO   = 16;
  localparam int CW    = $clog2(TMO);
  localparam int HALF  = TMO / 2;
  localparam int Q3    = (TMO * 3) / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_ok = 1'b1, vcc_gt_bat = 1'b1, tmo_active = 1'b0;
  logic [CW-1:0] tmo_cnt = '0;
  logic mr_n = 1'b1, arm_pin = 1'b1, pf_cmp = 1'b0;
  logic sel_main, sel_bat, seal, pfo;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bbs_seq #(.TMO_CYCLES(TMO)) u_bbs_seq (
    .clk_i(clk), .rst_ni(rst_n), .vcc_ok_i(vcc_ok), .vcc_gt_bat_i(vcc_gt_bat),
    .tmo_active_i(tmo_active), .tmo_cnt_i(tmo_cnt), .mr_ni(mr_n),
    .arm_pin_i(arm_pin), .pf_cmp_i(pf_cmp), .sel_main_o(sel_main),
    .sel_bat_o(sel_bat), .seal_o(seal), .pfo_o(pfo)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic int steady(input bit ok, input bit gt);
    return (!ok && !gt) ? 2 : 1;  // {bat,main}
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(2);
    // R12
    check("R12 sel_main", sel_main, 0);
    check("R12 sel_bat", sel_bat, 0);
    check("R12 seal", seal, 0);
    check("R12 pfo", pfo, 0);
    rst_n = 1'b1;
    tick(2);
    check("R1 main after reset", {sel_bat, sel_main}, 1);

    // seal arming sweep
    for (int c = 0; c < 16; c++) begin
      bit arm_h, mr_h, arm_q, mr_q, exp_arm;
      arm_h = c[0]; mr_h = c[1]; arm_q = c[2]; mr_q = c[3];
      exp_arm = !arm_h && mr_h && !arm_q && mr_q;
      vcc_ok = 1'b0; vcc_gt_bat = 1'b1; tick();
      vcc_ok = 1'b1; tick(2);
      for (int k = 0; k < TMO; k++) begin
        tmo_active = 1'b1;
        tmo_cnt = CW'(k);
        arm_pin = (k == HALF) ? arm_h : (k == Q3) ? arm_q : 1'b1;
        mr_n    = (k == HALF) ? mr_h  : (k == Q3) ? mr_q  : 1'b1;
        tick();
      end
      tmo_active = 1'b0; tmo_cnt = '0; arm_pin = 1'b1; mr_n = 1'b1;
      tick();
      check(exp_arm ? "R8 seal armed" : "R9 seal not armed", seal, exp_arm);
      vcc_ok = 1'b0; vcc_gt_bat = 1'b0; mr_n = 1'b0;
      tick(3);
      check(exp_arm ? "R10 sealed no battery" : "R3 battery selected",
            {sel_bat, sel_main}, exp_arm ? 0 : 2);
      check("R10 mr ignored by seal", seal, exp_arm);
      mr_n = 1'b1; vcc_gt_bat = 1'b1;
      tick(3);
      check("R2 main above battery", {sel_bat, sel_main}, 1);
      check("R11 seal held before rise", seal, exp_arm);
      vcc_ok = 1'b1;
      tick();
      check("R11 seal cleared on rise", seal, 0);
    end

    // switch transitions over every ordered pair
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        int ps, ts;
        vcc_ok = f[1]; vcc_gt_bat = f[0];
        tick(3);
        ps = steady(f[1], f[0]);
        check(f[1] ? "R1 settled" : "R2/R3 settled", {sel_bat, sel_main}, ps);
        vcc_ok = t[1]; vcc_gt_bat = t[0];
        ts = steady(t[1], t[0]);
        tick();
        check("R4 break cycle", {sel_bat, sel_main}, (ps == ts) ? ps : 0);
        tick();
        check("R4 make cycle", {sel_bat, sel_main}, ts);
      end
    end

    // power-fail output
    vcc_ok = 1'b1;
    for (int p = 0; p < 8; p++) begin
      tmo_active = p[2]; vcc_gt_bat = p[1]; pf_cmp = p[0];
      tmo_cnt = '0;
      tick();
      if (!p[1])     check("R6 pfo low below battery", pfo, 0);
      else if (p[2]) check("R5 pfo forced in timeout", pfo, 1);
      else           check("R7 pfo follows comparator", pfo, p[0]);
    end
    tmo_active = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule